// File: doc/BRIEF.md
# Locked Operand Swap Unit

This unit runs one exchange operation for a processor pipeline. It receives an opcode byte and the ModRM fields, all already fetched. It also receives the REX flags, an operand-size override flag, a 64-bit mode flag and a precomputed effective address. The unit swaps two operands. The operands are either two entries of a sixteen-entry, 64-bit general register file, or one register and a memory location. A register swap finishes in one cycle.

A memory swap is a locked read-modify-write on a simple request/acknowledge port. The unit first reads the memory operand. It then writes the old register value to memory, and finally loads the read data into the register. The lock output stays high for the whole sequence. The lock is applied unconditionally, so no prefix input is needed.

The register file resets to a known pattern. A combinational peek port shows the contents of any entry, so the result of each swap can be observed.

Top module: `xchg_unit`

## Requirements
- R1: Opcodes 0x90 to 0x97 swap register 0 with register {rex_b, opcode[2:0]}. The size is 32 bits by default, 16 bits with `opsize16`, and 64 bits when `rex_present` and `rex_w` are both set. These forms never touch memory.
- R2: When `modrm_mod` is 3, opcode 0x86 swaps two bytes and opcode 0x87 swaps two words, doublewords or quadwords (sizes as in R1). One operand is register {rex_r, modrm_reg} and the other is register {rex_b, modrm_rm}. The REX extension bits count only when `rex_present` is set.
- R3: A byte register number n from 4 to 7 selects bits 15:8 of register n-4 when `rex_present` is clear. When `rex_present` is set, it selects bits 7:0 of register n.
- R4: In 64-bit mode, a 32-bit register write clears bits 63:32. Outside 64-bit mode, a 32-bit write leaves bits 63:32 unchanged. 8-bit and 16-bit writes always leave the other bits unchanged.
- R5: A register swap raises `done` for one cycle, in the cycle after `start`. During a register swap, `mem_req` and `bus_lock` stay low.
- R6: When `modrm_mod` is not 3, the unit first holds a read request (`mem_we`=0) until it is acknowledged. It then holds a write request until that is acknowledged. The write data is the register operand's old value, zero-extended. Both requests carry the effective address. `mem_size` is 0, 1, 2 or 3 for 8, 16, 32 or 64 bits.
- R7: `bus_lock` is high from the first read-request cycle through the write-acknowledge cycle, and low at all other times.
- R8: In the cycle after the write acknowledge, the register operand holds the read data (with R3/R4 applied), `done` is high and `bus_lock` is low.
- R9: An operation is illegal if the opcode is not 0x86, 0x87 or 0x90 to 0x97, or if `rex_present` is set outside 64-bit mode. An illegal operation raises `illegal` in the cycle after `start`. It raises neither `done` nor any memory request, and it changes no register.
- R10: `busy` is high from the cycle after a memory start through its `done` cycle. A `start` seen while `busy` is high is ignored.
- R11: After reset, byte k of register i is (i·16 + k), and `done`, `illegal`, `busy`, `mem_req` and `bus_lock` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation with the current fields |
| opcode | input | 8 | Opcode byte |
| modrm_mod | input | 2 | ModRM mod field (3 = register operand) |
| modrm_reg | input | 3 | ModRM reg field |
| modrm_rm | input | 3 | ModRM r/m field |
| rex_present | input | 1 | A REX prefix is present |
| rex_w | input | 1 | REX width bit |
| rex_r | input | 1 | REX extension bit for the reg field |
| rex_b | input | 1 | REX extension bit for r/m and the opcode register |
| opsize16 | input | 1 | Operand-size override |
| long_mode | input | 1 | 64-bit mode |
| ea | input | AW | Effective address of the memory operand |
| busy | output | 1 | Memory sequence in progress |
| done | output | 1 | Operation complete pulse |
| illegal | output | 1 | Rejected encoding pulse |
| bus_lock | output | 1 | Bus lock |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Request address |
| mem_size | output | 2 | Access size code |
| mem_wdata | output | 64 | Write data |
| mem_rdata | input | 64 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Request acknowledge |
| peek_idx | input | 4 | Register index to observe |
| peek_data | output | 64 | Contents of the observed register |

## Verification
The assertions assume the memory side acknowledges only while `mem_req` is high. They also assume the memory side drives `mem_rdata` in the same cycle as the acknowledge of a read. The bench's responder raises `mem_ack` only after it sees a request at a falling edge, and it clears `mem_ack` before the next request. The assertions also assume the opcode and ModRM fields are steady on the edge that samples `start`. The bench changes inputs only on falling edges, and it holds `start` for exactly one cycle.

// File: rtl/xchg_pkg.sv
package xchg_pkg;

  localparam int DW   = 64;
  localparam int NREG = 16;
  localparam int IDXW = $clog2(NREG);

  typedef enum logic [1:0] {SZ8 = 2'd0, SZ16 = 2'd1, SZ32 = 2'd2, SZ64 = 2'd3} opsz_t;
  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR, ST_FIN} seq_st_t;

  function automatic logic [DW-1:0] size_mask(input opsz_t s);
    case (s)
      SZ8:     return {{(DW-8){1'b0}}, 8'hFF};
      SZ16:    return {{(DW-16){1'b0}}, 16'hFFFF};
      SZ32:    return {{(DW-32){1'b0}}, 32'hFFFF_FFFF};
      default: return {DW{1'b1}};
    endcase
  endfunction

  // Extract an operand from a register, right-justified.
  function automatic logic [DW-1:0] opnd_read(input logic [DW-1:0] r, input logic hi, input opsz_t s);
    if (hi) return {{(DW-8){1'b0}}, r[15:8]};
    return r & size_mask(s);
  endfunction

  // Merge a new operand value into an old register value.
  function automatic logic [DW-1:0] opnd_merge(input logic [DW-1:0] old, input logic [DW-1:0] v,
                                               input logic hi, input opsz_t s, input logic lm);
    if (hi) return {old[DW-1:16], v[7:0], old[7:0]};
    if (s == SZ32 && lm) return {{(DW-32){1'b0}}, v[31:0]};
    return (old & ~size_mask(s)) | (v & size_mask(s));
  endfunction

  // Byte register numbering: returns {high_byte, index}.
  function automatic logic [IDXW:0] byte_map(input logic [IDXW-1:0] n, input logic rex);
    if (!rex && n[IDXW-1:2] == {{(IDXW-3){1'b0}}, 1'b1})
      return {1'b1, {(IDXW-2){1'b0}}, n[1:0]};
    return {1'b0, n};
  endfunction

  function automatic logic [DW-1:0] reg_init(input int i);
    logic [DW-1:0] v;
    v = '0;
    for (int k = 0; k < DW/8; k++) v[8*k +: 8] = {4'(i), 4'(k)};
    return v;
  endfunction

endpackage

// File: rtl/xchg_decode.sv
module xchg_decode
  import xchg_pkg::*;
(
  input  logic [7:0]      opcode,
  input  logic [1:0]      modrm_mod,
  input  logic [2:0]      modrm_reg,
  input  logic [2:0]      modrm_rm,
  input  logic            rex_present,
  input  logic            rex_w,
  input  logic            rex_r,
  input  logic            rex_b,
  input  logic            opsize16,
  input  logic            long_mode,
  output logic            legal,
  output logic            is_mem,
  output logic [IDXW-1:0] a_idx,
  output logic            a_hi,
  output logic [IDXW-1:0] b_idx,
  output logic            b_hi,
  output opsz_t           size
);
  logic [IDXW-1:0] reg_n, rm_n;
  logic [IDXW:0]   reg_b, rm_b;
  opsz_t           wsz;

  assign reg_n = {rex_present & rex_r, modrm_reg};
  assign rm_n  = {rex_present & rex_b, modrm_rm};
  assign reg_b = byte_map(reg_n, rex_present);
  assign rm_b  = byte_map(rm_n, rex_present);
  assign wsz   = (rex_present && rex_w) ? SZ64 : (opsize16 ? SZ16 : SZ32);

  always_comb begin
    legal  = 1'b0;
    is_mem = 1'b0;
    a_idx  = '0;
    a_hi   = 1'b0;
    b_idx  = '0;
    b_hi   = 1'b0;
    size   = wsz;
    if (opcode == 8'h86) begin
      legal  = 1'b1;
      size   = SZ8;
      is_mem = (modrm_mod != 2'b11);
      a_hi   = reg_b[IDXW];
      a_idx  = reg_b[IDXW-1:0];
      b_hi   = rm_b[IDXW];
      b_idx  = rm_b[IDXW-1:0];
    end else if (opcode == 8'h87) begin
      legal  = 1'b1;
      is_mem = (modrm_mod != 2'b11);
      a_idx  = reg_n;
      b_idx  = rm_n;
    end else if (opcode[7:3] == 5'b10010) begin
      legal  = 1'b1;
      b_idx  = {rex_present & rex_b, opcode[2:0]};
    end
    if (rex_present && !long_mode) legal = 1'b0;
  end
endmodule

// File: rtl/xchg_regfile.sv
module xchg_regfile
  import xchg_pkg::*;
#(
  parameter int N = NREG,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] a_idx,
  input  logic [IW-1:0] b_idx,
  input  logic [IW-1:0] p_idx,
  output logic [DW-1:0] a_data,
  output logic [DW-1:0] b_data,
  output logic [DW-1:0] p_data,
  input  logic          wr_a,
  input  logic [IW-1:0] wa_idx,
  input  logic          wa_hi,
  input  logic [DW-1:0] wa_val,
  input  logic          wr_b,
  input  logic [IW-1:0] wb_idx,
  input  logic          wb_hi,
  input  logic [DW-1:0] wb_val,
  input  opsz_t         wsize,
  input  logic          wlm
);
  logic [DW-1:0] rf_q [N];

  for (genvar gi = 0; gi < N; gi++) begin : g_ent
    logic [DW-1:0] q, nxt;
    always_comb begin
      nxt = q;
      if (wr_a && wa_idx == IW'(gi)) nxt = opnd_merge(nxt, wa_val, wa_hi, wsize, wlm);
      if (wr_b && wb_idx == IW'(gi)) nxt = opnd_merge(nxt, wb_val, wb_hi, wsize, wlm);
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= reg_init(gi);
      else        q <= nxt;
    end
    assign rf_q[gi] = q;
  end

  assign a_data = rf_q[a_idx];
  assign b_data = rf_q[b_idx];
  assign p_data = rf_q[p_idx];

  AST_SECOND_WRITE_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_b |-> wr_a); // R2
endmodule

// File: rtl/xchg_seq.sv
module xchg_seq
  import xchg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic legal,
  input  logic is_mem,
  input  logic mem_ack,
  output logic accept,
  output logic mem_start,
  output logic reg_swap,
  output logic rd_take,
  output logic wb_take,
  output logic busy,
  output logic done,
  output logic illegal,
  output logic mem_req,
  output logic mem_we,
  output logic bus_lock
);
  seq_st_t st, st_n;
  logic    illegal_q;

  assign accept    = start && (st == ST_IDLE);
  assign mem_start = accept && legal && is_mem;
  assign reg_swap  = accept && legal && !is_mem;
  assign rd_take   = (st == ST_RD) && mem_ack;
  assign wb_take   = (st == ST_WR) && mem_ack;

  always_comb begin
    st_n = st;
    case (st)
      ST_IDLE: if (accept && legal) st_n = is_mem ? ST_RD : ST_FIN;
      ST_RD:   if (mem_ack) st_n = ST_WR;
      ST_WR:   if (mem_ack) st_n = ST_FIN;
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      illegal_q <= 1'b0;
    end else begin
      st        <= st_n;
      illegal_q <= accept && !legal;
    end
  end

  assign busy     = (st != ST_IDLE);
  assign done     = (st == ST_FIN);
  assign illegal  = illegal_q;
  assign mem_req  = (st == ST_RD) || (st == ST_WR);
  assign mem_we   = (st == ST_WR);
  assign bus_lock = (st == ST_RD) || (st == ST_WR);

  AST_WRITE_AFTER_READ_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we) |-> $past(mem_req && !mem_we && mem_ack)); // R6
  AST_UNLOCK_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_lock) |-> done); // R7
  AST_START_WHILE_BUSY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && start && !mem_ack) |=> busy); // R10
endmodule

// File: rtl/xchg_unit.sv
module xchg_unit
  import xchg_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [7:0]      opcode,
  input  logic [1:0]      modrm_mod,
  input  logic [2:0]      modrm_reg,
  input  logic [2:0]      modrm_rm,
  input  logic            rex_present,
  input  logic            rex_w,
  input  logic            rex_r,
  input  logic            rex_b,
  input  logic            opsize16,
  input  logic            long_mode,
  input  logic [AW-1:0]   ea,
  output logic            busy,
  output logic            done,
  output logic            illegal,
  output logic            bus_lock,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [1:0]      mem_size,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata,
  input  logic            mem_ack,
  input  logic [IDXW-1:0] peek_idx,
  output logic [DW-1:0]   peek_data
);
  logic            d_legal, d_mem, d_a_hi, d_b_hi;
  logic [IDXW-1:0] d_a_idx, d_b_idx;
  opsz_t           d_size;

  logic accept, mem_start, reg_swap, rd_take, wb_take;

  logic [IDXW-1:0] c_idx;
  logic            c_hi, c_lm;
  opsz_t           c_size;
  logic [AW-1:0]   c_addr;
  logic [DW-1:0]   c_wdata, c_rdata;
  logic [DW-1:0]   a_data, b_data;

  xchg_decode i_dec (
    .opcode(opcode), .modrm_mod(modrm_mod), .modrm_reg(modrm_reg), .modrm_rm(modrm_rm),
    .rex_present(rex_present), .rex_w(rex_w), .rex_r(rex_r), .rex_b(rex_b),
    .opsize16(opsize16), .long_mode(long_mode),
    .legal(d_legal), .is_mem(d_mem), .a_idx(d_a_idx), .a_hi(d_a_hi),
    .b_idx(d_b_idx), .b_hi(d_b_hi), .size(d_size)
  );

  xchg_seq i_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .legal(d_legal), .is_mem(d_mem),
    .mem_ack(mem_ack), .accept(accept), .mem_start(mem_start), .reg_swap(reg_swap),
    .rd_take(rd_take), .wb_take(wb_take), .busy(busy), .done(done), .illegal(illegal),
    .mem_req(mem_req), .mem_we(mem_we), .bus_lock(bus_lock)
  );

  xchg_regfile #(.N(NREG)) i_rf (
    .clk(clk), .rst_n(rst_n),
    .a_idx(d_a_idx), .b_idx(d_b_idx), .p_idx(peek_idx),
    .a_data(a_data), .b_data(b_data), .p_data(peek_data),
    .wr_a(reg_swap || wb_take),
    .wa_idx(reg_swap ? d_a_idx : c_idx),
    .wa_hi(reg_swap ? d_a_hi : c_hi),
    .wa_val(reg_swap ? opnd_read(b_data, d_b_hi, d_size) : c_rdata),
    .wr_b(reg_swap), .wb_idx(d_b_idx), .wb_hi(d_b_hi),
    .wb_val(opnd_read(a_data, d_a_hi, d_size)),
    .wsize(reg_swap ? d_size : c_size),
    .wlm(reg_swap ? long_mode : c_lm)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_idx   <= '0;
      c_hi    <= 1'b0;
      c_lm    <= 1'b0;
      c_size  <= SZ8;
      c_addr  <= '0;
      c_wdata <= '0;
      c_rdata <= '0;
    end else begin
      if (mem_start) begin
        c_idx   <= d_a_idx;
        c_hi    <= d_a_hi;
        c_lm    <= long_mode;
        c_size  <= d_size;
        c_addr  <= ea;
        c_wdata <= opnd_read(a_data, d_a_hi, d_size);
      end
      if (rd_take) c_rdata <= mem_rdata & size_mask(c_size);
    end
  end

  assign mem_addr  = c_addr;
  assign mem_size  = c_size;
  assign mem_wdata = c_wdata;

  AST_REQ_UNDER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> bus_lock); // R7
  AST_REQ_HELD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr))); // R6
  AST_DONE_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !bus_lock); // R8
  AST_REG_SWAP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_swap |=> (done && !mem_req)); // R5
  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!done && !mem_req && !busy)); // R9
  AST_ACCEPT_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_start, reg_swap, accept && !d_legal})); // R9
endmodule

// File: tb/test_xchg_unit.sv
module test_xchg_unit;
  localparam int PERIOD = 10;
  localparam int AW = 32;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [7:0] opcode = 8'h00;
  logic [1:0] modrm_mod = 2'b11;
  logic [2:0] modrm_reg = '0, modrm_rm = '0;
  logic rex_present = 0, rex_w = 0, rex_r = 0, rex_b = 0, opsize16 = 0, long_mode = 0;
  logic [AW-1:0] ea = '0;
  logic busy, done, illegal, bus_lock, mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [1:0] mem_size;
  logic [63:0] mem_wdata, peek_data;
  logic [63:0] mem_rdata = '0;
  logic mem_ack = 1'b0;
  logic [3:0] peek_idx = '0;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [63:0] mdl [16];

  always #(PERIOD/2) clk = ~clk;

  xchg_unit #(.AW(AW)) i_xchg_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .modrm_mod(modrm_mod),
    .modrm_reg(modrm_reg), .modrm_rm(modrm_rm), .rex_present(rex_present), .rex_w(rex_w),
    .rex_r(rex_r), .rex_b(rex_b), .opsize16(opsize16), .long_mode(long_mode), .ea(ea),
    .busy(busy), .done(done), .illegal(illegal), .bus_lock(bus_lock), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .peek_idx(peek_idx), .peek_data(peek_data)
  );

  function automatic logic [63:0] b_init(int i);
    logic [63:0] v = '0;
    for (int k = 0; k < 8; k++) v = v | (64'(i * 16 + k) << (8 * k));
    return v;
  endfunction
  function automatic logic [63:0] b_mask(int sz);
    return (sz == 64) ? '1 : ((64'd1 << sz) - 64'd1);
  endfunction
  function automatic logic [63:0] b_read(logic [63:0] v, bit hi, int sz);
    return hi ? ((v >> 8) & 64'hFF) : (v & b_mask(sz));
  endfunction
  function automatic logic [63:0] b_merge(logic [63:0] old, logic [63:0] v, bit hi, int sz, bit lm);
    if (hi) return (old & ~64'hFF00) | ((v & 64'hFF) << 8);
    if (sz == 32 && lm) return v & 64'hFFFF_FFFF;
    return (old & ~b_mask(sz)) | (v & b_mask(sz));
  endfunction
  // Register-number to {index, high-byte} for the byte forms (R3).
  task automatic b_map(input int n, input bit rex, output int idx, output bit hi);
    if (!rex && n >= 4 && n < 8) begin idx = n - 4; hi = 1; end
    else begin idx = n; hi = 0; end
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cmp_regs(input string tag);
    for (int i = 0; i < 16; i++) begin
      peek_idx = 4'(i);
      #1;
      chk(tag, peek_data, mdl[i]);
    end
  endtask

  task automatic drive(input logic [7:0] op, input logic [1:0] md, input logic [2:0] rg,
                       input logic [2:0] rm, input bit rp, input bit w, input bit r,
                       input bit b, input bit o16, input bit lm, input logic [AW-1:0] addr);
    opcode = op; modrm_mod = md; modrm_reg = rg; modrm_rm = rm;
    rex_present = rp; rex_w = w; rex_r = r; rex_b = b; opsize16 = o16; long_mode = lm; ea = addr;
  endtask

  function automatic int b_size(logic [7:0] op, bit rp, bit w, bit o16);
    if (op == 8'h86) return 8;
    if (rp && w) return 64;
    return o16 ? 16 : 32;
  endfunction

  task automatic do_reg(input string tag, input logic [7:0] op, input logic [2:0] rg,
                        input logic [2:0] rm, input bit rp, input bit w, input bit r,
                        input bit b, input bit o16, input bit lm);
    int sz, ai, bi;
    bit ah, bh;
    logic [63:0] va, vb;
    sz = b_size(op, rp, w, o16);
    if (op == 8'h86) begin
      b_map((rp && r) ? rg + 8 : rg, rp, ai, ah);
      b_map((rp && b) ? rm + 8 : rm, rp, bi, bh);
    end else if (op == 8'h87) begin
      ai = (rp && r) ? rg + 8 : rg; ah = 0;
      bi = (rp && b) ? rm + 8 : rm; bh = 0;
    end else begin
      ai = 0; ah = 0;
      bi = (rp && b) ? op[2:0] + 8 : op[2:0]; bh = 0;
    end
    va = b_read(mdl[ai], ah, sz);
    vb = b_read(mdl[bi], bh, sz);
    mdl[ai] = b_merge(mdl[ai], vb, ah, sz, lm);
    mdl[bi] = b_merge(mdl[bi], va, bh, sz, lm);
    @(negedge clk);
    drive(op, 2'b11, rg, rm, rp, w, r, b, o16, lm, '0);
    start = 1;
    @(negedge clk);
    start = 0;
    chk("R5 done", 64'(done), 64'd1);
    chk("R5 no lock/req", 64'({bus_lock, mem_req}), 64'd0);
    cmp_regs(tag);
  endtask

  task automatic do_mem(input logic [7:0] op, input logic [2:0] rg, input bit rp, input bit w,
                        input bit r, input bit o16, input bit lm, input logic [AW-1:0] addr,
                        input logic [63:0] rd, input int wrd, input int wwr, input bit poke);
    int sz, ri;
    bit rh;
    logic [63:0] old;
    logic [1:0] code;
    sz = b_size(op, rp, w, o16);
    code = (sz == 8) ? 2'd0 : (sz == 16) ? 2'd1 : (sz == 32) ? 2'd2 : 2'd3;
    if (op == 8'h86) b_map((rp && r) ? rg + 8 : rg, rp, ri, rh);
    else begin ri = (rp && r) ? rg + 8 : rg; rh = 0; end
    old = b_read(mdl[ri], rh, sz);
    @(negedge clk);
    drive(op, 2'b01, rg, 3'd0, rp, w, r, 1'b0, o16, lm, addr);
    start = 1;
    @(negedge clk);
    start = 0;
    for (int c = 0; c <= wrd; c++) begin
      chk("R6 read req", 64'({mem_req, mem_we}), 64'b10);
      chk("R6 addr", 64'(mem_addr), 64'(addr));
      chk("R6 size", 64'(mem_size), 64'(code));
      chk("R7 lock in read", 64'(bus_lock), 64'd1);
      chk("R10 busy", 64'(busy), 64'd1);
      if (c == wrd) begin mem_rdata = rd; mem_ack = 1; end
      else if (poke && c == 0) begin
        drive(8'h87, 2'b11, 3'd0, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, lm, '0);
        start = 1;  // R10: must be ignored
      end
      @(negedge clk);
      start = 0;
      mem_ack = 0;
    end
    for (int c = 0; c <= wwr; c++) begin
      chk("R6 write req", 64'({mem_req, mem_we}), 64'b11);
      chk("R6 wdata", mem_wdata, old);
      chk("R7 lock in write", 64'(bus_lock), 64'd1);
      if (c == wwr) mem_ack = 1;
      @(negedge clk);
      mem_ack = 0;
    end
    mdl[ri] = b_merge(mdl[ri], rd, rh, sz, lm);
    chk("R8 done", 64'(done), 64'd1);
    chk("R8 unlocked", 64'({bus_lock, mem_req}), 64'd0);
    cmp_regs("R8 register loaded");
  endtask

  task automatic do_bad(input logic [7:0] op, input logic [1:0] md, input bit rp, input bit lm);
    @(negedge clk);
    drive(op, md, 3'd2, 3'd5, rp, 1'b1, 1'b0, 1'b0, 1'b0, lm, 32'h40);
    start = 1;
    @(negedge clk);
    start = 0;
    chk("R9 illegal", 64'(illegal), 64'd1);
    chk("R9 quiet", 64'({done, mem_req, bus_lock}), 64'd0);
    @(negedge clk);
    chk("R9 no late req", 64'({mem_req, illegal}), 64'd0);
    cmp_regs("R9 regs unchanged");
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 16; i++) mdl[i] = b_init(i);
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R11 reset state
    chk("R11 outputs", 64'({done, illegal, busy, mem_req, bus_lock}), 64'd0);
    cmp_regs("R11 reset pattern");

    // R2/R3/R4 sweep over register-register forms
    for (int lm = 0; lm < 2; lm++)
      for (int rp = 0; rp <= lm; rp++)
        for (int cfg = 0; cfg < 4; cfg++) begin
          bit w, o16;
          logic [7:0] op;
          op  = (cfg == 0) ? 8'h86 : 8'h87;
          w   = (cfg == 3);
          o16 = (cfg == 2);
          if (w && rp == 0) continue;
          for (int rg = 0; rg < 8; rg++)
            for (int rm = 0; rm < 8; rm++)
              do_reg((op == 8'h86) ? "R3 byte swap" : (lm != 0 ? "R4 word swap" : "R2 word swap"),
                     op, 3'(rg), 3'(rm), bit'(rp), w, bit'((rg + rm) & 1), bit'(rg & 1), o16, bit'(lm));
        end

    // R1 accumulator short forms
    for (int lm = 0; lm < 2; lm++)
      for (int rp = 0; rp <= lm; rp++)
        for (int cfg = 0; cfg < 3; cfg++) begin
          if (cfg == 2 && rp == 0) continue;
          for (int n = 0; n < 8; n++)
            for (int b = 0; b <= rp; b++)
              do_reg("R1 accumulator swap", 8'h90 + 8'(n), 3'd0, 3'd0, bit'(rp),
                     cfg == 2, 1'b0, bit'(b), cfg == 1, bit'(lm));
        end

    // R6/R7/R8 memory forms, with wait states and a busy-time start (R10)
    do_mem(8'h86, 3'd4, 0, 0, 0, 0, 0, 32'h0000_1000, 64'hFFFF_FFFF_FFFF_FFA5, 0, 0, 0);
    do_mem(8'h86, 3'd4, 1, 0, 1, 0, 1, 32'h0000_2004, 64'h0000_0000_0000_003C, 2, 1, 1);
    do_mem(8'h87, 3'd3, 1, 1, 0, 0, 1, 32'hDEAD_BEE8, 64'h0123_4567_89AB_CDEF, 1, 3, 0);
    do_mem(8'h87, 3'd6, 0, 0, 0, 1, 1, 32'h0000_0010, 64'h5555_5555_5555_BEEF, 0, 2, 1);
    do_mem(8'h87, 3'd5, 0, 0, 0, 0, 1, 32'h0000_0020, 64'hAAAA_AAAA_8765_4321, 3, 0, 0);
    do_mem(8'h87, 3'd2, 0, 0, 0, 0, 0, 32'h0000_0030, 64'hAAAA_AAAA_1357_9BDF, 0, 0, 0);

    // R9 illegal encodings
    do_bad(8'h88, 2'b11, 0, 1);
    do_bad(8'h00, 2'b00, 0, 0);
    do_bad(8'h85, 2'b11, 0, 1);
    do_bad(8'h98, 2'b11, 0, 1);
    do_bad(8'h87, 2'b11, 1, 0);
    do_bad(8'h86, 2'b00, 1, 0);
    do_bad(8'h93, 2'b11, 1, 0);

    // Check after illegal that a swap still works (R2)
    do_reg("R2 after illegal", 8'h87, 3'd1, 3'd7, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    finish_run();
  end
endmodule